// File: doc/BRIEF.md
# Fuse Array Sequencing Controller

This block sits on a simple register bus and manages a small one-time-programmable fuse array. It also keeps a shadow copy of each fuse word. Software picks a fuse word through an address field in a control register. It then does one of three things: writes a program-data register to burn bits into that word, sets a start bit to read the word into a result register, or sets a reload bit to copy every fuse word into its shadow register. Programming is guarded by a 16-bit unlock key. The key must be loaded into the control register before every program attempt.

Each operation runs a fixed phase sequence timed in clock cycles from a timing register. A setup wait comes first. Then follow a leading relax pad, an active strobe and a trailing relax pad. The strobe count covers both relax pads. Only one operation runs at a time. A busy flag covers the whole operation. Any register write that arrives while busy is rejected and raises a sticky error flag.

Top module: `fuse_seq_ctrl`

Bus word addresses: 0 control (plain write loads the address and key fields), 1 control set alias, 2 control clear alias, 3 timing, 4 program data, 5 read start, 6 read result, 16+i shadow word i. The register at address 0 holds the word address in bits [IDX_W-1:0], busy in bit 8, error in bit 9, reload in bit 10 and the unlock key in bits [31:16]. The timing register holds wait in [7:0], relax in [15:8], program strobe in [23:16] and read strobe in [31:24].

## Requirements
- R1: After reset, the control register, the read result and every shadow word read 0, and the timing register reads its reset parameter value.
- R2: Writing ones to address 1 ORs them into the address and key fields, and writing ones to address 2 clears those bits. Busy, error and reload are not changed by these writes.
- R3: A program operation sets the addressed fuse word to the bitwise OR of its old value and the program data. Fuse bits never go from 1 to 0.
- R4: A write to address 4 while the key field does not hold 0x3E77 sets the error bit (bit 9), starts no operation and leaves the fuses unchanged.
- R5: The key field reads 0 after any write to address 4, whether or not the key was correct.
- R6: Writing 1 to bit 0 of address 5 starts a read of the addressed word. The fuse value appears at address 6 in the same cycle that busy falls.
- R7: Busy rises in the cycle after an operation is accepted and stays high for wait+1+max(strobe+1, 2*relax+3) cycles. The strobe is the program strobe for a program and the read strobe for a read. The active strobe lasts strobe+1-2*(relax+1) cycles, and at least 1 cycle.
- R8: A write to any of addresses 0 to 5 while busy sets the error bit and has no other effect.
- R9: The error bit stays set until a write to address 2 with bit 9 set. Writes to address 0 or to address 1 do not clear it.
- R10: Setting bit 10 through address 1 starts a reload. The reload bit reads 1 until every shadow word holds its fuse word, then clears by itself. Busy lasts WORDS times the read duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the register at bus_addr (combinational) |

## Verification
The bench builds the controller with WORDS=4, so a reload is short and every fuse word, including the top one, can be programmed, read back and compared after each reload. The timing values are small. This lets the bench sweep wait and relax over 0 to 2 and the strobe counts over a spread of values. The sweep covers both the clamped case, where the relax pads alone set the length, and the case where the strobe count does. Each busy length is compared against the closed form.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;

  localparam int DW    = 32;
  localparam int CNT_W = 8;
  localparam int BA_W  = 5;

  localparam logic [15:0] UNLOCK_KEY = 16'h3E77;

  localparam int BIT_BUSY   = 8;
  localparam int BIT_ERR    = 9;
  localparam int BIT_RELOAD = 10;
  localparam int KEY_LSB    = 16;

  localparam logic [BA_W-1:0] A_CTRL  = 5'd0;
  localparam logic [BA_W-1:0] A_SET   = 5'd1;
  localparam logic [BA_W-1:0] A_CLR   = 5'd2;
  localparam logic [BA_W-1:0] A_TIM   = 5'd3;
  localparam logic [BA_W-1:0] A_PDATA = 5'd4;
  localparam logic [BA_W-1:0] A_RDGO  = 5'd5;
  localparam logic [BA_W-1:0] A_RDAT  = 5'd6;
  localparam int              SHADOW_BASE = 16;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_PAD_A, PH_STROBE, PH_PAD_B
  } phase_e;

  typedef enum logic [1:0] {
    OP_NONE, OP_READ, OP_PROG, OP_RELOAD
  } op_e;

  // active strobe cycles: strobe count less both relax pads, never below 1
  function automatic logic [CNT_W:0] strobe_active(input logic [CNT_W-1:0] strobe,
                                                    input logic [CNT_W-1:0] relax);
    logic [CNT_W+1:0] span;
    logic [CNT_W+1:0] pads;
    span = {2'b00, strobe} + 1'b1;
    pads = ({2'b00, relax} + 1'b1) << 1;
    if (span > pads) return (CNT_W+1)'(span - pads);
    return (CNT_W+1)'(1);
  endfunction

endpackage

// File: rtl/fuse_seq_regs.sv
module fuse_seq_regs
  import fuse_seq_pkg::*;
#(
  parameter int          IDX_W      = 3,
  parameter logic [31:0] TIMING_RST = 32'h0408_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [BA_W-1:0]   bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              busy,
  input  logic              reload_done,
  output logic [IDX_W-1:0]  word_addr,
  output logic [15:0]       key,
  output logic              err,
  output logic              reload,
  output logic [DW-1:0]     timing,
  output logic [DW-1:0]     pdata,
  output logic              start_read,
  output logic              start_prog,
  output logic              start_reload,
  output logic              wr_collide,
  output logic              err_clear
);

  logic wr_writable, wr_ok, key_ok, prog_denied;

  assign wr_writable  = bus_wr && (bus_addr <= A_RDGO);
  assign wr_collide   = wr_writable && busy;
  assign wr_ok        = bus_wr && !busy;
  assign key_ok       = (key == UNLOCK_KEY);
  assign start_prog   = wr_ok && (bus_addr == A_PDATA) && key_ok;
  assign prog_denied  = wr_ok && (bus_addr == A_PDATA) && !key_ok;
  assign start_read   = wr_ok && (bus_addr == A_RDGO) && bus_wdata[0];
  assign start_reload = wr_ok && (bus_addr == A_SET) && bus_wdata[BIT_RELOAD];
  assign err_clear    = wr_ok && (bus_addr == A_CLR) && bus_wdata[BIT_ERR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_addr <= '0;
      key       <= '0;
      err       <= 1'b0;
      reload    <= 1'b0;
      timing    <= TIMING_RST;
      pdata     <= '0;
    end else begin
      if (wr_collide || prog_denied) err <= 1'b1;
      else if (err_clear)            err <= 1'b0;

      if (reload_done)       reload <= 1'b0;
      else if (start_reload) reload <= 1'b1;

      if (wr_ok) begin
        case (bus_addr)
          A_CTRL: begin
            word_addr <= bus_wdata[IDX_W-1:0];
            key       <= bus_wdata[KEY_LSB +: 16];
          end
          A_SET: begin
            word_addr <= word_addr | bus_wdata[IDX_W-1:0];
            key       <= key | bus_wdata[KEY_LSB +: 16];
          end
          A_CLR: begin
            word_addr <= word_addr & ~bus_wdata[IDX_W-1:0];
            key       <= key & ~bus_wdata[KEY_LSB +: 16];
          end
          A_TIM:   timing <= bus_wdata;
          A_PDATA: begin
            pdata <= bus_wdata;
            key   <= '0;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/fuse_seq_timer.sv
module fuse_seq_timer
  import fuse_seq_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_read,
  input  logic             start_prog,
  input  logic             start_reload,
  input  logic [CNT_W-1:0] t_wait,
  input  logic [CNT_W-1:0] t_relax,
  input  logic [CNT_W-1:0] t_sprog,
  input  logic [CNT_W-1:0] t_sread,
  output logic             busy,
  output op_e              op,
  output logic [IDX_W-1:0] idx,
  output logic             strobe_on,
  output logic             word_fire,
  output logic             last_fire
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  phase_e         phase_q;
  logic [CNT_W:0] cnt_q;
  logic [CNT_W:0] act_len;
  logic           start_any;

  assign start_any = start_read || start_prog || start_reload;
  assign act_len   = strobe_active((op == OP_PROG) ? t_sprog : t_sread, t_relax);
  assign busy      = (phase_q != PH_IDLE);
  assign strobe_on = (phase_q == PH_STROBE);
  assign word_fire = (phase_q == PH_PAD_B) && (cnt_q == '0);
  assign last_fire = word_fire && ((op != OP_RELOAD) || (idx == LAST_IDX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      op      <= OP_NONE;
      idx     <= '0;
    end else if (start_any) begin
      phase_q <= PH_SETUP;
      cnt_q   <= {1'b0, t_wait};
      idx     <= '0;
      op      <= start_prog ? OP_PROG : (start_read ? OP_READ : OP_RELOAD);
    end else if (phase_q != PH_IDLE) begin
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        case (phase_q)
          PH_SETUP: begin
            phase_q <= PH_PAD_A;
            cnt_q   <= {1'b0, t_relax};
          end
          PH_PAD_A: begin
            phase_q <= PH_STROBE;
            cnt_q   <= act_len - 1'b1;
          end
          PH_STROBE: begin
            phase_q <= PH_PAD_B;
            cnt_q   <= {1'b0, t_relax};
          end
          PH_PAD_B: begin
            if (last_fire) begin
              phase_q <= PH_IDLE;
              op      <= OP_NONE;
            end else begin
              phase_q <= PH_SETUP;
              cnt_q   <= {1'b0, t_wait};
              idx     <= idx + 1'b1;
            end
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/fuse_seq_array.sv
module fuse_seq_array
  import fuse_seq_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int IDX_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                word_fire,
  input  op_e                 op,
  input  logic [IDX_W-1:0]    word_addr,
  input  logic [IDX_W-1:0]    idx,
  input  logic [DW-1:0]       pdata,
  output logic [DW-1:0]       rdata,
  output logic [WORDS*DW-1:0] shadow_flat,
  output logic [WORDS*DW-1:0] fuse_flat
);

  logic [DW-1:0] fuse_q   [WORDS];
  logic [DW-1:0] shadow_q [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) begin
        fuse_q[i]   <= '0;
        shadow_q[i] <= '0;
      end
      rdata <= '0;
    end else if (word_fire) begin
      case (op)
        OP_PROG:   fuse_q[word_addr] <= fuse_q[word_addr] | pdata;
        OP_READ:   rdata <= fuse_q[word_addr];
        OP_RELOAD: shadow_q[idx] <= fuse_q[idx];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_flat
    assign shadow_flat[g*DW +: DW] = shadow_q[g];
    assign fuse_flat[g*DW +: DW]   = fuse_q[g];
  end

endmodule

// File: rtl/fuse_seq_ctrl.sv
module fuse_seq_ctrl
  import fuse_seq_pkg::*;
#(
  parameter int          WORDS      = 8,
  parameter logic [31:0] TIMING_RST = 32'h0408_0001
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [4:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata
);

  localparam int IDX_W = (WORDS > 2) ? $clog2(WORDS) : 1;

  logic [IDX_W-1:0]    word_addr, seq_idx;
  logic [15:0]         key;
  logic                err, reload, err_clear, wr_collide;
  logic [DW-1:0]       timing, pdata, rdata;
  logic                start_read, start_prog, start_reload;
  logic                seq_busy, strobe_on, word_fire, last_fire;
  op_e                 seq_op;
  logic [WORDS*DW-1:0] shadow_flat, fuse_flat;
  logic [DW-1:0]       ctrl_word;

  fuse_seq_regs #(.IDX_W(IDX_W), .TIMING_RST(TIMING_RST)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(seq_busy),
    .reload_done(last_fire && (seq_op == OP_RELOAD)),
    .word_addr(word_addr), .key(key), .err(err), .reload(reload),
    .timing(timing), .pdata(pdata), .start_read(start_read),
    .start_prog(start_prog), .start_reload(start_reload),
    .wr_collide(wr_collide), .err_clear(err_clear)
  );

  fuse_seq_timer #(.WORDS(WORDS), .IDX_W(IDX_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .start_read(start_read),
    .start_prog(start_prog), .start_reload(start_reload),
    .t_wait(timing[7:0]), .t_relax(timing[15:8]),
    .t_sprog(timing[23:16]), .t_sread(timing[31:24]),
    .busy(seq_busy), .op(seq_op), .idx(seq_idx), .strobe_on(strobe_on),
    .word_fire(word_fire), .last_fire(last_fire)
  );

  fuse_seq_array #(.WORDS(WORDS), .IDX_W(IDX_W)) array_i (
    .clk(clk), .rst_n(rst_n), .word_fire(word_fire), .op(seq_op),
    .word_addr(word_addr), .idx(seq_idx), .pdata(pdata), .rdata(rdata),
    .shadow_flat(shadow_flat), .fuse_flat(fuse_flat)
  );

  always_comb begin
    ctrl_word                  = '0;
    ctrl_word[IDX_W-1:0]       = word_addr;
    ctrl_word[BIT_BUSY]        = seq_busy;
    ctrl_word[BIT_ERR]         = err;
    ctrl_word[BIT_RELOAD]      = reload;
    ctrl_word[KEY_LSB +: 16]   = key;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_word;
      A_TIM:   bus_rdata = timing;
      A_PDATA: bus_rdata = pdata;
      A_RDAT:  bus_rdata = rdata;
      default: ;
    endcase
    for (int i = 0; i < WORDS; i++) begin
      if (bus_addr == BA_W'(SHADOW_BASE + i)) bus_rdata = shadow_flat[i*DW +: DW];
    end
  end

endmodule

// File: rtl/fuse_seq_ctrl_chk.sv
module fuse_seq_ctrl_chk #(
  parameter int FW = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          err,
  input logic          reload,
  input logic          last_fire,
  input logic          wr_collide,
  input logic          err_clear,
  input logic          strobe_on,
  input logic [FW-1:0] fuse_flat
);

  assert_fuse_only_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(fuse_flat) & ~fuse_flat) == '0));

  assert_busy_ends_with_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(last_fire));

  assert_strobe_inside_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_on |-> busy);

  assert_collision_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_collide |=> err);

  assert_collision_keeps_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_collide && !last_fire) |=> busy);

  assert_error_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> $past(err_clear));

  assert_reload_self_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reload) |-> $past(last_fire));

endmodule

bind fuse_seq_ctrl fuse_seq_ctrl_chk #(.FW(WORDS*32)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(seq_busy), .err(err), .reload(reload),
  .last_fire(last_fire), .wr_collide(wr_collide), .err_clear(err_clear),
  .strobe_on(strobe_on), .fuse_flat(fuse_flat)
);

// File: tb/fuse_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module fuse_seq_ctrl_tb_top;

  localparam int W = 4;
  localparam logic [31:0] TRST = 32'h0408_0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int tests = 0;
  int fails = 0;
  logic [31:0] exp_fuse [W];

  fuse_seq_ctrl #(.WORDS(W), .TIMING_RST(TRST)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #2.5 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] v;
    n = 0;
    rd(5'd0, v);
    while (v[8] && n < 5000) begin
      n++;
      @(negedge clk);
      rd(5'd0, v);
    end
    @(negedge clk);
  endtask

  function automatic int exp_dur(input int w, input int r, input int s);
    int m;
    m = s + 1;
    if (2 * r + 3 > m) m = 2 * r + 3;
    return w + 1 + m;
  endfunction

  function automatic logic [31:0] tim(input int w, input int r, input int sp, input int sr);
    return {8'(sr), 8'(sp), 8'(r), 8'(w)};
  endfunction

  task automatic do_prog(input int a, input logic [31:0] d, input int edur);
    int n;
    logic [31:0] v;
    wr(5'd0, {16'h3E77, 14'd0, 2'(a)});
    wr(5'd4, d);
    wait_idle(n);
    check("R7 program busy length", 32'(n), 32'(edur));
    rd(5'd0, v);
    check("R5 key cleared after program", {16'd0, v[31:16]}, 32'd0);
    exp_fuse[a] = exp_fuse[a] | d;
  endtask

  task automatic do_read(input int a, input int edur);
    int n;
    logic [31:0] v;
    wr(5'd0, {30'd0, 2'(a)});
    wr(5'd5, 32'd1);
    wait_idle(n);
    check("R7 read busy length", 32'(n), 32'(edur));
    rd(5'd6, v);
    check("R6 read result", v, exp_fuse[a]);
  endtask

  initial begin
    logic [31:0] v;
    int n, k;
    for (int i = 0; i < W; i++) exp_fuse[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'd0, v); check("R1 control", v, 32'd0);
    rd(5'd6, v); check("R1 read result", v, 32'd0);
    rd(5'd3, v); check("R1 timing", v, TRST);
    for (int i = 0; i < W; i++) begin
      rd(5'(16 + i), v); check("R1 shadow", v, 32'd0);
    end

    // R2 set and clear aliases
    wr(5'd0, 32'd1);            rd(5'd0, v); check("R2 plain write", v, 32'd1);
    wr(5'd1, 32'd2);            rd(5'd0, v); check("R2 set alias", v, 32'd3);
    wr(5'd2, 32'd1);            rd(5'd0, v); check("R2 clear alias", v, 32'd2);
    wr(5'd1, 32'h3E77_0000);    rd(5'd0, v); check("R2 set key", v, 32'h3E77_0002);
    wr(5'd2, 32'hFFFF_0000);    rd(5'd0, v); check("R2 clear key", v, 32'h0000_0002);

    // R3/R7 program sweep
    k = 0;
    for (int w = 0; w < 3; w++) begin
      for (int r = 0; r < 3; r++) begin
        foreach (exp_fuse[s]) begin
          int sp;
          sp = (s == 0) ? 0 : (s == 1) ? 4 : (s == 2) ? 9 : 13;
          wr(5'd3, tim(w, r, sp, 2));
          do_prog(k % W, 32'h1 << (k % 32) | 32'(k) << 20, exp_dur(w, r, sp));
          k++;
        end
      end
    end
    wr(5'd3, tim(0, 0, 3, 3));
    do_prog(1, 32'h0000_00F0, exp_dur(0, 0, 3));
    do_prog(1, 32'h0000_0F0F, exp_dur(0, 0, 3));
    for (int a = 0; a < W; a++) begin
      wr(5'd0, {30'd0, 2'(a)});
      wr(5'd5, 32'd1);
      wait_idle(n);
      rd(5'd6, v);
      check("R3 fuse holds OR of programs", v, exp_fuse[a]);
    end

    // R6/R7 read sweep
    k = 0;
    for (int w = 0; w < 3; w++) begin
      for (int r = 0; r < 3; r++) begin
        for (int si = 0; si < 6; si++) begin
          int sr;
          sr = (si == 0) ? 0 : (si == 1) ? 1 : (si == 2) ? 2 : (si == 3) ? 3 : (si == 4) ? 5 : 8;
          wr(5'd3, tim(w, r, 6, sr));
          do_read(k % W, exp_dur(w, r, sr));
          k++;
        end
      end
    end

    // R4/R5 program without key
    wr(5'd3, tim(1, 1, 5, 5));
    wr(5'd0, {16'h3E76, 14'd0, 2'd2});
    wr(5'd4, 32'hFFFF_FFFF);
    rd(5'd0, v);
    check("R4 no busy without key", {31'd0, v[8]}, 32'd0);
    check("R4 error set without key", {31'd0, v[9]}, 32'd1);
    check("R5 key cleared after failed attempt", {16'd0, v[31:16]}, 32'd0);
    do_read(2, exp_dur(1, 1, 5));

    // R9 error sticky
    wr(5'd1, 32'h0000_0200); rd(5'd0, v);
    check("R9 set alias keeps error", {31'd0, v[9]}, 32'd1);
    wr(5'd0, 32'd0); rd(5'd0, v);
    check("R9 plain write keeps error", {31'd0, v[9]}, 32'd1);
    wr(5'd2, 32'h0000_0200); rd(5'd0, v);
    check("R9 clear alias clears error", {31'd0, v[9]}, 32'd0);

    // R8 writes while busy
    wr(5'd3, tim(20, 0, 2, 2));
    wr(5'd0, 32'd0);
    wr(5'd5, 32'd1);
    wr(5'd3, 32'd0);
    wr(5'd0, {16'h3E77, 16'd3});
    wr(5'd4, 32'hFFFF_FFFF);
    wait_idle(n);
    rd(5'd0, v);
    check("R8 error after busy write", {31'd0, v[9]}, 32'd1);
    check("R8 address and key unchanged", {v[31:16], 14'd0, v[1:0]}, 32'd0);
    rd(5'd3, v); check("R8 timing unchanged", v, tim(20, 0, 2, 2));
    rd(5'd6, v); check("R8 read still completes", v, exp_fuse[0]);
    wr(5'd2, 32'h0000_0200);
    wr(5'd3, tim(0, 0, 2, 2));
    do_read(3, exp_dur(0, 0, 2));

    // R10 reload
    for (int t = 0; t < 2; t++) begin
      int w, r, sr;
      w = t; r = t + 1; sr = 4 * t + 1;
      wr(5'd3, tim(w, r, 2, sr));
      do_prog(t, 32'h8000_0000 >> t, exp_dur(w, r, 2));
      wr(5'd1, 32'h0000_0400);
      rd(5'd0, v);
      check("R10 reload bit set while running", {31'd0, v[10]}, 32'd1);
      wait_idle(n);
      check("R10 reload busy length", 32'(n), 32'(W * exp_dur(w, r, sr)));
      rd(5'd0, v);
      check("R10 reload bit self-clears", {31'd0, v[10]}, 32'd0);
      for (int i = 0; i < W; i++) begin
        rd(5'(16 + i), v); check("R10 shadow equals fuse", v, exp_fuse[i]);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule